// File: doc/BRIEF.md
# Fabric Error Detect and Capture Unit

This unit sits beside an interconnect fabric and watches for four classes of transaction error: a local access window miss, a coherency violation, an unreachable target and a stash sent to several targets at once. Each class arrives as a single-cycle pulse. Every pulse comes with the transaction's 40-bit address, an 8-bit source ID and a 5-bit capture type. The unit keeps one sticky detect bit per class. It also records the attributes of the first error it accepts, and it raises a level interrupt while any detected class has its interrupt enabled.

Software reaches the unit through a 32-bit word-addressed read/write port. It can mask detection per class and enable the interrupt per class. It reads back the detect word and the captured attributes. To clear status it writes the detect word back: every bit written as one is cleared. Clearing the capture-valid flag arms the capture registers again for the next accepted error.

Top module: `fab_err_unit`

## Requirements
- R1: After reset, every register at byte offsets 0x00 to 0x18 reads zero and `irq_o` is low.
- R2: A pulse on `evt_hit[i]` sets detect bit i (offset 0x00, class i at bit i for i in 0..3) unless that class is disabled. The bit stays set until software clears it.
- R3: Bit i of the disable register (offset 0x04) stops class i from setting its detect bit, from taking part in capture and from affecting the interrupt.
- R4: When an accepted event arrives while capture-valid (detect bit 31) is clear, the unit loads the capture registers and sets bit 31. The type goes to detect bits 30:26, the source ID to bits 25:18 of offset 0x0C and address bits 39:32 to bits 7:0 of offset 0x10. Address bits 31:0 go to offset 0x14, and the accepted class bits of that cycle go to bits 3:0 of offset 0x18.
- R5: While capture-valid is set, later events set their detect bits but leave every captured field unchanged.
- R6: A write to offset 0x00 clears exactly the detect bits written as one. Clearing bit 31 re-arms capture and zeroes the type field.
- R7: An accepted event of class i in the same cycle as a write that clears detect bit i leaves bit i set. If bit 31 is cleared in that cycle, no capture is loaded in that cycle.
- R8: `irq_o` is high exactly while some detect bit i has interrupt-enable bit i set (offset 0x08). It follows the register state without a cycle of delay.
- R9: The disable and interrupt-enable registers store bits 3:0 of a write; their bits 31:4 read zero.
- R10: Writes to offsets 0x0C to 0x18 have no effect. Bits 30:0 of the detect word cannot be set by a write. Unused or unaligned offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_hit | input | 4 | One-cycle error pulse per class |
| evt_addr | input | 40 | Address of the failing transaction |
| evt_src | input | 8 | Source ID of the failing transaction |
| evt_ctype | input | 5 | Capture type of the failing transaction |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong sticky or mask state shows on the detect word read from the port in the cycle after the offending pulse or write. Through `irq_o` it shows in that same cycle, because the interrupt is a direct function of the stored bits. A capture that is overwritten or lost shows in the next read of the capture words. A wrong capture-valid state also shows there, and again after the following event, since that event is then captured or not when it should be the other way. An error in the same-cycle priority between a clear and an event shows as a detect bit that has dropped one cycle after the write.

// File: rtl/fab_err_pkg.sv
package fab_err_pkg;
    localparam int NCLS    = 4;
    localparam int ADDR_W  = 40;
    localparam int SRC_W   = 8;
    localparam int CT_W    = 5;
    localparam int WORD_W  = 32;

    // word index of each register (byte offset / 4)
    localparam logic [2:0] IX_DET   = 3'd0;
    localparam logic [2:0] IX_DIS   = 3'd1;
    localparam logic [2:0] IX_INTEN = 3'd2;
    localparam logic [2:0] IX_ATTR  = 3'd3;
    localparam logic [2:0] IX_ADRH  = 3'd4;
    localparam logic [2:0] IX_ADRL  = 3'd5;
    localparam logic [2:0] IX_ATTR2 = 3'd6;

    // field positions
    localparam int CAPV_BIT = 31;
    localparam int CT_LSB   = 26;
    localparam int SRC_LSB  = 18;
endpackage

// File: rtl/fab_err_cfg.sv
module fab_err_cfg
    import fab_err_pkg::*;
#(
    parameter int N = NCLS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_we,
    input  logic [4:0]   reg_addr,
    input  logic [N-1:0] wdata_lo,
    output logic         wr_det,
    output logic [N-1:0] dis_q,
    output logic [N-1:0] inten_q
);
    typedef struct packed {
        logic [N-1:0] dis;
        logic [N-1:0] inten;
    } cfg_t;

    cfg_t st_d, st_q;
    logic aligned;
    logic [2:0] ix;

    always_comb begin
        aligned = (reg_addr[1:0] == 2'b00);
        ix      = reg_addr[4:2];
        wr_det  = reg_we && aligned && (ix == IX_DET);
        st_d    = st_q;
        if (reg_we && aligned && ix == IX_DIS)
            st_d.dis = wdata_lo;
        if (reg_we && aligned && ix == IX_INTEN)
            st_d.inten = wdata_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dis_q   = st_q.dis;
    assign inten_q = st_q.inten;

    // R9: stored value follows only writes to its own offset
    a_r9_dis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 5'h04) |=> $stable(dis_q));
    a_r9_inten_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 5'h08) |=> $stable(inten_q));
endmodule

// File: rtl/fab_err_detect.sv
module fab_err_detect
    import fab_err_pkg::*;
#(
    parameter int N = NCLS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_hit,
    input  logic [N-1:0] dis,
    input  logic         wr_det,
    input  logic [N-1:0] clr_bits,
    input  logic         clr_capv,
    output logic [N-1:0] qual,
    output logic         cap_clr,
    output logic [N-1:0] det_q
);
    typedef struct packed {
        logic [N-1:0] det;
    } det_t;

    det_t st_d, st_q;
    logic [N-1:0] clr_mask;

    always_comb begin
        qual     = evt_hit & ~dis;
        clr_mask = wr_det ? clr_bits : '0;
        cap_clr  = wr_det && clr_capv;
        st_d     = st_q;
        // new events take priority over a clear in the same cycle
        st_d.det = (st_q.det & ~clr_mask) | qual;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign det_q = st_q.det;

    // R2: a set bit survives any cycle without a clear of it
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(det_q) & ~$past(clr_mask) & ~det_q) == '0));
    // R3: a disabled, clear class stays clear
    a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((dis & ~det_q) != '0) |=> ((det_q & $past(dis & ~det_q)) == '0));
    // R7: event beats the clear
    a_r7_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_hit & ~dis & clr_mask) != '0)
        |=> ((det_q & $past(evt_hit & ~dis & clr_mask)) == $past(evt_hit & ~dis & clr_mask)));
endmodule

// File: rtl/fab_err_capture.sv
module fab_err_capture
    import fab_err_pkg::*;
#(
    parameter int N  = NCLS,
    parameter int AW = ADDR_W,
    parameter int SW = SRC_W,
    parameter int TW = CT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  qual,
    input  logic          cap_clr,
    input  logic [AW-1:0] evt_addr,
    input  logic [SW-1:0] evt_src,
    input  logic [TW-1:0] evt_ctype,
    output logic          capv_q,
    output logic [TW-1:0] ctype_q,
    output logic [SW-1:0] src_q,
    output logic [AW-1:0] addr_q,
    output logic [N-1:0]  cls_q
);
    typedef struct packed {
        logic          v;
        logic [TW-1:0] ct;
        logic [SW-1:0] src;
        logic [AW-1:0] addr;
        logic [N-1:0]  cls;
    } cap_t;

    cap_t st_d, st_q;
    logic load;

    always_comb begin
        st_d = st_q;
        load = !st_q.v && (qual != '0);
        if (st_q.v && cap_clr) begin
            st_d.v  = 1'b0;
            st_d.ct = '0;
        end else if (load) begin
            st_d.v    = 1'b1;
            st_d.ct   = evt_ctype;
            st_d.src  = evt_src;
            st_d.addr = evt_addr;
            st_d.cls  = qual;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capv_q  = st_q.v;
    assign ctype_q = st_q.ct;
    assign src_q   = st_q.src;
    assign addr_q  = st_q.addr;
    assign cls_q   = st_q.cls;

    // R5: captured data frozen while valid
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        capv_q |=> ($stable(addr_q) && $stable(src_q) && $stable(cls_q)));
    // R4: an accepted event with capture idle sets valid
    a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!capv_q && qual != '0) |=> capv_q);
    // R7: no load in the cycle valid is cleared
    a_r7_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (capv_q && cap_clr) |=> (!capv_q && $stable(addr_q)));
endmodule

// File: rtl/fab_err_rdmux.sv
module fab_err_rdmux
    import fab_err_pkg::*;
#(
    parameter int N  = NCLS,
    parameter int AW = ADDR_W,
    parameter int SW = SRC_W,
    parameter int TW = CT_W
) (
    input  logic [4:0]        reg_addr,
    input  logic [N-1:0]      det,
    input  logic [N-1:0]      dis,
    input  logic [N-1:0]      inten,
    input  logic              capv,
    input  logic [TW-1:0]     ctype,
    input  logic [SW-1:0]     src,
    input  logic [AW-1:0]     addr,
    input  logic [N-1:0]      cls,
    output logic [WORD_W-1:0] rdata
);
    localparam int HI_W = AW - WORD_W;

    always_comb begin
        rdata = '0;
        if (reg_addr[1:0] == 2'b00) begin
            unique case (reg_addr[4:2])
                IX_DET: begin
                    rdata[N-1:0]                = det;
                    rdata[CT_LSB +: TW]         = ctype;
                    rdata[CAPV_BIT]             = capv;
                end
                IX_DIS:   rdata[N-1:0]          = dis;
                IX_INTEN: rdata[N-1:0]          = inten;
                IX_ATTR:  rdata[SRC_LSB +: SW]  = src;
                IX_ADRH:  rdata[HI_W-1:0]       = addr[AW-1:WORD_W];
                IX_ADRL:  rdata                 = addr[WORD_W-1:0];
                IX_ATTR2: rdata[N-1:0]          = cls;
                default:  rdata                 = '0;
            endcase
        end
    end
endmodule

// File: rtl/fab_err_unit.sv
module fab_err_unit
    import fab_err_pkg::*;
#(
    parameter int N  = NCLS,
    parameter int AW = ADDR_W,
    parameter int SW = SRC_W,
    parameter int TW = CT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_hit,
    input  logic [AW-1:0]     evt_addr,
    input  logic [SW-1:0]     evt_src,
    input  logic [TW-1:0]     evt_ctype,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic          wr_det, cap_clr, capv;
    logic [N-1:0]  dis, inten, qual, det, cls;
    logic [TW-1:0] ctype;
    logic [SW-1:0] src;
    logic [AW-1:0] addr;

    fab_err_cfg #(.N(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .wdata_lo(reg_wdata[N-1:0]), .wr_det(wr_det),
        .dis_q(dis), .inten_q(inten)
    );

    fab_err_detect #(.N(N)) u_det (
        .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .dis(dis),
        .wr_det(wr_det), .clr_bits(reg_wdata[N-1:0]),
        .clr_capv(reg_wdata[CAPV_BIT]), .qual(qual),
        .cap_clr(cap_clr), .det_q(det)
    );

    fab_err_capture #(.N(N), .AW(AW), .SW(SW), .TW(TW)) u_cap (
        .clk(clk), .rst_n(rst_n), .qual(qual), .cap_clr(cap_clr),
        .evt_addr(evt_addr), .evt_src(evt_src), .evt_ctype(evt_ctype),
        .capv_q(capv), .ctype_q(ctype), .src_q(src), .addr_q(addr),
        .cls_q(cls)
    );

    fab_err_rdmux #(.N(N), .AW(AW), .SW(SW), .TW(TW)) u_rd (
        .reg_addr(reg_addr), .det(det), .dis(dis), .inten(inten),
        .capv(capv), .ctype(ctype), .src(src), .addr(addr), .cls(cls),
        .rdata(reg_rdata)
    );

    assign irq_o = |(det & inten);

    // R8: interrupt only rises after an event or a register write
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(evt_hit != '0) || $past(reg_we)));
    // R1: reset leaves the interrupt low
    a_r1_reset_low: assert property (@(posedge clk)
        $past(!rst_n) |-> !irq_o);
endmodule

// File: tb/fab_err_unit_bench.sv
`timescale 1ns/1ps
module fab_err_unit_bench;
    typedef struct {
        logic        is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  evt_hit = 0;
    logic [39:0] evt_addr = 0;
    logic [7:0]  evt_src = 0;
    logic [4:0]  evt_ctype = 0;
    logic        reg_we = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    item_t q[$];

    always #10 clk = ~clk;

    fab_err_unit u_fab_err_unit (
        .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .evt_addr(evt_addr),
        .evt_src(evt_src), .evt_ctype(evt_ctype), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    // monitor: pop and compare each expected item away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic irq_is(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic evt(input logic [3:0] c, input logic [39:0] a,
                       input logic [7:0] s, input logic [4:0] t);
        @(negedge clk);
        evt_hit = c; evt_addr = a; evt_src = s; evt_ctype = t;
        @(negedge clk);
        evt_hit = 0;
    endtask

    initial begin
        #(20.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int i = 0; i < 7; i++) rd(5'(i * 4), 32'h0, "R1 reset value");
        irq_is(0, "R1 irq low");
        // R9 config widths
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, 32'hF, "R9 inten bits");
        wr(5'h04, 32'hFFFF_FFF0);
        rd(5'h04, 32'h0, "R9 disable bits");
        // R2/R4 first capture
        evt(4'b0010, 40'hAB_1234_5678, 8'h5A, 5'h13);
        rd(5'h00, 32'hCC00_0002, "R4 detect word");
        rd(5'h0C, 32'h0168_0000, "R4 source id");
        rd(5'h10, 32'h0000_00AB, "R4 addr high");
        rd(5'h14, 32'h1234_5678, "R4 addr low");
        rd(5'h18, 32'h2, "R4 class bits");
        irq_is(1, "R8 irq on enabled detect");
        // R5 later event does not overwrite
        evt(4'b1000, 40'h01_0000_0001, 8'h11, 5'h03);
        rd(5'h00, 32'hCC00_000A, "R5 detect accumulates");
        rd(5'h14, 32'h1234_5678, "R5 addr low kept");
        rd(5'h0C, 32'h0168_0000, "R5 source kept");
        rd(5'h18, 32'h2, "R5 class kept");
        // R10 ignored writes, unused offsets
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'h0);
        wr(5'h00, 32'h0);
        rd(5'h10, 32'h0000_00AB, "R10 addr high write ignored");
        rd(5'h14, 32'h1234_5678, "R10 addr low write ignored");
        rd(5'h00, 32'hCC00_000A, "R10 zero write no effect");
        rd(5'h1C, 32'h0, "R10 unused offset");
        rd(5'h01, 32'h0, "R10 unaligned offset");
        // R6 partial and full clear
        wr(5'h00, 32'h0000_0002);
        rd(5'h00, 32'hCC00_0008, "R6 partial clear");
        irq_is(1, "R8 irq still pending");
        wr(5'h00, 32'hCC00_0008);
        rd(5'h00, 32'h0, "R6 full clear");
        irq_is(0, "R8 irq drops");
        // R3 disabled class
        wr(5'h04, 32'h1);
        evt(4'b0001, 40'h99_9999_9999, 8'h77, 5'h07);
        rd(5'h00, 32'h0, "R3 disabled not detected");
        rd(5'h18, 32'h2, "R3 disabled not captured");
        irq_is(0, "R3 no irq");
        // R6 re-arm, R8 enable gating
        wr(5'h04, 32'h0);
        wr(5'h08, 32'h4);
        evt(4'b1000, 40'h22_0000_00F0, 8'hC3, 5'h00);
        rd(5'h00, 32'h8000_0008, "R6 re-armed capture");
        rd(5'h0C, 32'h030C_0000, "R6 new source");
        rd(5'h10, 32'h22, "R6 new addr high");
        irq_is(0, "R8 class not enabled");
        evt(4'b0100, 40'h0, 8'h0, 5'h0A);
        rd(5'h00, 32'h8000_000C, "R8 detect");
        irq_is(1, "R8 enabled class raises irq");
        // R7 same-cycle event and clear
        @(negedge clk);
        reg_we = 1; reg_addr = 5'h00; reg_wdata = 32'h8000_000C;
        evt_hit = 4'b0100; evt_addr = 40'h33_3333_3333; evt_ctype = 5'h1F;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0; evt_hit = 0;
        rd(5'h00, 32'h0000_0004, "R7 event wins over clear");
        rd(5'h10, 32'h22, "R7 no capture on clear cycle");
        irq_is(1, "R7 irq held");
        // R4 simultaneous classes
        wr(5'h00, 32'h4);
        evt(4'b0011, 40'h44_5555_6666, 8'h01, 5'h01);
        rd(5'h00, 32'h8400_0003, "R4 two classes");
        rd(5'h18, 32'h3, "R4 class bits both");
        rd(5'h0C, 32'h0004_0000, "R4 source one");
        rd(5'h14, 32'h5555_6666, "R4 addr low");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule